// File: doc/BRIEF.md
# NAND Page Program Sequencer

This block sits on the host side of a byte-wide NAND flash device and writes one page into it without help from software. A single `start` pulse hands it a page address. The sequencer selects the chip and lifts write protection. It sends the data-load opcode, the address bytes and a full page of data bytes, which it fetches one index at a time from a local buffer. It then sends the program opcode and waits on the device's ready/busy line. When the device is ready again, it sends the status opcode and reads one status byte. It reports pass or fail with a one-cycle `done` pulse. Finally it deselects the chip and restores write protection.

Every byte on the flash bus is one bus period. In a period the strobe (`nf_we_n` for writes, `nf_re_n` for the status read) is low for `LO_CYC` clocks and then high for `HI_CYC` clocks. The byte and the latch-enable lines are held steady for the whole period. The ready line is brought in through a two-flop synchroniser. It is ignored for the first `GUARD_CYC` clocks of the wait, so that a device that has not yet dropped ready is not mistaken for one that has finished. If the device stays busy for `TIMEOUT_CYC` clocks, the sequencer gives up and reports a fail.

The states are IDLE, ENABLE, CMD_LOAD, ADDR, DATA, CMD_PROG, WAIT, CMD_STAT, STAT and FINISH. The transitions are:
- IDLE→ENABLE on `start`.
- ENABLE→CMD_LOAD, CMD_LOAD→ADDR, CMD_PROG→WAIT and CMD_STAT→STAT at the end of one period.
- ADDR→DATA after `ADDR_CYC` periods.
- DATA→CMD_PROG after `PAGE_BYTES` periods.
- WAIT→CMD_STAT when the guard has expired and synchronised ready is high.
- WAIT→FINISH on timeout.
- STAT→FINISH at the end of the read period.
- FINISH→IDLE after one clock.

Top module: `nand_prog_seq`

## Requirements
- R1: Out of reset and in IDLE, the outputs hold their inactive levels: `nf_ce_n`=1, `nf_wp_n`=0, `nf_we_n`=1, `nf_re_n`=1, `nf_cle`=0, `nf_ale`=0, `nf_io_oe`=0, `buf_rd`=0, `done`=0 and `busy`=0. `busy` is 1 in every other state.
- R2: `start` is acted on only in IDLE, where `page_addr` is captured. A `start` pulse or a change of `page_addr` during an operation leaves the pin sequence unchanged.
- R3: After `start` there is one ENABLE period, with `nf_ce_n`=0, `nf_wp_n`=1 and no strobe, before the first write strobe. CE stays low and WP stays high until FINISH.
- R4: Every bus period is `LO_CYC` clocks of strobe low followed by `HI_CYC` clocks of strobe high. Output data and latch enables are stable for the whole period. `nf_we_n` and `nf_re_n` are never low together.
- R5: The first write period carries opcode 80h with `nf_cle`=1 and `nf_ale`=0.
- R6: Next come `ADDR_CYC` address periods with `nf_ale`=1 throughout. They carry `page_addr` least significant byte first. ALE is 0 in the data periods.
- R7: Next come `PAGE_BYTES` data periods, with CLE and ALE low. In period i, `buf_idx`=i, `buf_rd`=1 and `nf_io_out` equals `buf_data`. Indices run from 0 upward.
- R8: Opcode 10h is sent with CLE high, and then WAIT begins with no strobe. The ready line passes through two flops. WAIT ends in the first WAIT clock c (counted from 0) for which c ≥ `GUARD_CYC` and the synchronised ready is 1.
- R9: After WAIT, opcode 70h is sent with CLE high. One read period follows with `nf_io_oe`=0. The status byte is sampled in the last low clock of `nf_re_n`.
- R10: The result is a pass exactly when status bit 6 is 1 and status bit 0 is 0.
- R11: If ready is not seen within `TIMEOUT_CYC` WAIT clocks, the block goes straight to FINISH and reports a fail, without a status opcode.
- R12: FINISH lasts one clock. In it `done`=1 and `pass` carries the result, with `nf_ce_n`=1 and `nf_wp_n`=0. IDLE follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a page program (IDLE only) |
| page_addr | input | 8*ADDR_CYC | Page address, sent LS byte first |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Result, valid with `done` |
| buf_rd | output | 1 | Buffer read active during data periods |
| buf_idx | output | $clog2(PAGE_BYTES) | Buffer byte index |
| buf_data | input | 8 | Buffer byte at `buf_idx` (same cycle) |
| nf_ce_n | output | 1 | Chip enable, active low |
| nf_wp_n | output | 1 | Write protect, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_io_out | output | 8 | Byte driven to the flash |
| nf_io_oe | output | 1 | Output enable for `nf_io_out` |
| nf_io_in | input | 8 | Byte from the flash |
| nf_rdy | input | 1 | Ready (1) / busy (0) from the flash |

## Verification
The bench models the device's ready line and its status output and predicts every pin in every clock.

Several corner cases are aimed at designs that get the wait wrong:
- A device that never drops ready tests the guard window. A design without the guard would read status one clock after the program opcode, while the device is still busy.
- A long busy time and a busy line that never returns check the synchroniser latency and the timeout path. An off-by-one there would shift every later pin by a clock, or would send a stray 70h after the timeout.

Other cases cover the status byte and the captured inputs:
- Status bytes with bit 6 clear, or with bit 0 set, must fail. A decoder that looks at only one of the two bits would report a pass.
- Outside the read strobe the bench floats a deliberately failing byte onto `nf_io_in`, so a design that samples the status in the wrong clock gives the wrong verdict.
- A `start` pulse and an address change in the middle of the address phase would corrupt the address bytes of a design that does not capture them.

// File: rtl/nps_pkg.sv
package nps_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ENABLE,
        S_CMD_LOAD,
        S_ADDR,
        S_DATA,
        S_CMD_PROG,
        S_WAIT,
        S_CMD_STAT,
        S_STAT,
        S_FINISH
    } nps_state_e;

    localparam logic [7:0] OP_LOAD = 8'h80;
    localparam logic [7:0] OP_PROG = 8'h10;
    localparam logic [7:0] OP_STAT = 8'h70;

    // status byte: bit 6 ready, bit 0 failure
    localparam logic [7:0] STAT_MASK = 8'h41;
    localparam logic [7:0] STAT_GOOD = 8'h40;

endpackage

// File: rtl/nps_strobe.sv
module nps_strobe #(
    parameter int LO_CYC = 2,
    parameter int HI_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic low,
    output logic sample,
    output logic last
);
    localparam int PER = LO_CYC + HI_CYC;
    localparam int PW  = $clog2(PER + 1);

    logic [PW-1:0] cnt;

    assign low    = run && (cnt < PW'(LO_CYC));
    assign sample = run && (cnt == PW'(LO_CYC - 1));
    assign last   = run && (cnt == PW'(PER - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || last)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // R4: phase counter never leaves its period
    a_r4_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < PW'(PER));

    // R4: a period always begins with the strobe low
    a_r4_period_start: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !$past(run)) |-> low);

endmodule

// File: rtl/nps_sync2.sv
module nps_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= 1'b0;
            q    <= 1'b0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/nps_wait_timer.sv
module nps_wait_timer #(
    parameter int GUARD_CYC   = 4,
    parameter int TIMEOUT_CYC = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic guard_ok,
    output logic expired
);
    localparam int CW = $clog2(TIMEOUT_CYC + 1);

    logic [CW-1:0] cnt;

    assign guard_ok = active && (cnt >= CW'(GUARD_CYC));
    assign expired  = active && (cnt == CW'(TIMEOUT_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!active)
            cnt <= '0;
        else if (cnt != CW'(TIMEOUT_CYC - 1))
            cnt <= cnt + 1'b1;
    end

    // R11: wait counter bounded by the timeout
    a_r11_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(TIMEOUT_CYC));

    // R8: counter restarts at zero when a wait begins
    a_r8_wait_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !$past(active)) |-> (cnt == '0));

endmodule

// File: rtl/nand_prog_seq.sv
module nand_prog_seq #(
    parameter int ADDR_CYC    = 3,
    parameter int PAGE_BYTES  = 528,
    parameter int LO_CYC      = 2,
    parameter int HI_CYC      = 2,
    parameter int GUARD_CYC   = 4,
    parameter int TIMEOUT_CYC = 100000,
    localparam int AW = 8 * ADDR_CYC,
    localparam int IW = $clog2(PAGE_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] page_addr,
    output logic          busy,
    output logic          done,
    output logic          pass,
    output logic          buf_rd,
    output logic [IW-1:0] buf_idx,
    input  logic [7:0]    buf_data,
    output logic          nf_ce_n,
    output logic          nf_wp_n,
    output logic          nf_cle,
    output logic          nf_ale,
    output logic          nf_we_n,
    output logic          nf_re_n,
    output logic [7:0]    nf_io_out,
    output logic          nf_io_oe,
    input  logic [7:0]    nf_io_in,
    input  logic          nf_rdy
);
    import nps_pkg::*;

    nps_state_e    state_q, state_d;
    logic [IW-1:0] idx_q;
    logic [AW-1:0] addr_sh;
    logic [7:0]    stat_q;
    logic          pass_q;
    logic          run, ph_low, ph_sample, ph_last;
    logic          rdy_s, guard_ok, expired;

    assign run = (state_q == S_ENABLE)   || (state_q == S_CMD_LOAD) ||
                 (state_q == S_ADDR)     || (state_q == S_DATA)     ||
                 (state_q == S_CMD_PROG) || (state_q == S_CMD_STAT) ||
                 (state_q == S_STAT);

    nps_strobe #(.LO_CYC(LO_CYC), .HI_CYC(HI_CYC)) u_strobe (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .low    (ph_low),
        .sample (ph_sample),
        .last   (ph_last)
    );

    nps_sync2 u_rdy_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (nf_rdy),
        .q     (rdy_s)
    );

    nps_wait_timer #(.GUARD_CYC(GUARD_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (state_q == S_WAIT),
        .guard_ok (guard_ok),
        .expired  (expired)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (start) state_d = S_ENABLE;
            S_ENABLE:   if (ph_last) state_d = S_CMD_LOAD;
            S_CMD_LOAD: if (ph_last) state_d = S_ADDR;
            S_ADDR:     if (ph_last && idx_q == IW'(ADDR_CYC - 1)) state_d = S_DATA;
            S_DATA:     if (ph_last && idx_q == IW'(PAGE_BYTES - 1)) state_d = S_CMD_PROG;
            S_CMD_PROG: if (ph_last) state_d = S_WAIT;
            S_WAIT: begin
                if (guard_ok && rdy_s) state_d = S_CMD_STAT;
                else if (expired)      state_d = S_FINISH;
            end
            S_CMD_STAT: if (ph_last) state_d = S_STAT;
            S_STAT:     if (ph_last) state_d = S_FINISH;
            S_FINISH:   state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            addr_sh <= '0;
            stat_q  <= '0;
            pass_q  <= 1'b0;
        end else begin
            if (state_d != state_q)
                idx_q <= '0;
            else if (ph_last && (state_q == S_ADDR || state_q == S_DATA))
                idx_q <= idx_q + 1'b1;

            if (state_q == S_IDLE && start)
                addr_sh <= page_addr;
            else if (state_q == S_ADDR && ph_last)
                addr_sh <= addr_sh >> 8;

            if (state_q == S_STAT && ph_sample)
                stat_q <= nf_io_in;

            if (state_q == S_STAT && ph_last)
                pass_q <= ((stat_q & STAT_MASK) == STAT_GOOD);
            else if (state_q == S_WAIT && state_d == S_FINISH)
                pass_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        nf_ce_n   = 1'b1;
        nf_wp_n   = 1'b0;
        nf_cle    = 1'b0;
        nf_ale    = 1'b0;
        nf_we_n   = 1'b1;
        nf_re_n   = 1'b1;
        nf_io_oe  = 1'b0;
        nf_io_out = 8'h00;
        buf_rd    = 1'b0;
        buf_idx   = '0;
        done      = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_ENABLE, S_WAIT: begin
                nf_ce_n = 1'b0;
                nf_wp_n = 1'b1;
            end
            S_CMD_LOAD, S_CMD_PROG, S_CMD_STAT: begin
                nf_ce_n   = 1'b0;
                nf_wp_n   = 1'b1;
                nf_cle    = 1'b1;
                nf_io_oe  = 1'b1;
                nf_we_n   = !ph_low;
                nf_io_out = (state_q == S_CMD_LOAD) ? OP_LOAD :
                            (state_q == S_CMD_PROG) ? OP_PROG : OP_STAT;
            end
            S_ADDR: begin
                nf_ce_n   = 1'b0;
                nf_wp_n   = 1'b1;
                nf_ale    = 1'b1;
                nf_io_oe  = 1'b1;
                nf_we_n   = !ph_low;
                nf_io_out = addr_sh[7:0];
            end
            S_DATA: begin
                nf_ce_n   = 1'b0;
                nf_wp_n   = 1'b1;
                nf_io_oe  = 1'b1;
                nf_we_n   = !ph_low;
                buf_rd    = 1'b1;
                buf_idx   = idx_q;
                nf_io_out = buf_data;
            end
            S_STAT: begin
                nf_ce_n = 1'b0;
                nf_wp_n = 1'b1;
                nf_re_n = !ph_low;
            end
            S_FINISH: done = 1'b1;
            default: ;
        endcase
    end

    assign busy = (state_q != S_IDLE);
    assign pass = pass_q;

    // R4: never both strobes at once
    a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nf_we_n && !nf_re_n));

    // R4: byte held across the rising write edge
    a_r4_io_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nf_we_n) |-> $stable(nf_io_out));

    // R6: address and command latches exclusive
    a_r6_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(nf_ale && nf_cle));

    // R3: writes only with chip selected and protection lifted
    a_r3_write_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        !nf_we_n |-> (nf_wp_n && !nf_ce_n));

    // R8: status opcode only after synchronised ready
    a_r8_ready_seen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CMD_STAT && $past(state_q) == S_WAIT) |-> $past(rdy_s));

    // R9: bus released while reading
    a_r9_read_released: assert property (@(posedge clk) disable iff (!rst_n)
        !nf_re_n |-> !nf_io_oe);

    // R12: done is a single-cycle pulse followed by idle
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

endmodule

// File: tb/nand_prog_seq_test.sv
module nand_prog_seq_test;
    localparam int ADDR_CYC = 3;
    localparam int PAGE     = 528;
    localparam int LO       = 2;
    localparam int HI       = 1;
    localparam int PER      = LO + HI;
    localparam int GUARD    = 6;
    localparam int TMO      = 200;
    localparam int AW       = 8 * ADDR_CYC;
    localparam int IW       = $clog2(PAGE);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] page_addr = '0;
    logic          busy, done, pass, buf_rd;
    logic [IW-1:0] buf_idx;
    logic [7:0]    buf_data;
    logic          nf_ce_n, nf_wp_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_io_oe;
    logic [7:0]    nf_io_out, nf_io_in;
    logic          nf_rdy = 1'b1;
    logic [7:0]    dev_status = 8'h00;

    int checks = 0;
    int failures = 0;
    int cyc_n = 0;
    int rdy_low_left = 0;
    logic h1 = 1'b0, h2 = 1'b0;

    always #4 clk = ~clk;

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 13 + 7) ^ (i >> 8));
    endfunction

    assign buf_data = pat(int'(buf_idx));
    // device drives status only while read strobe is low; junk (fail-looking) otherwise
    assign nf_io_in = nf_re_n ? 8'hBF : dev_status;

    nand_prog_seq #(
        .ADDR_CYC(ADDR_CYC), .PAGE_BYTES(PAGE), .LO_CYC(LO), .HI_CYC(HI),
        .GUARD_CYC(GUARD), .TIMEOUT_CYC(TMO)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .page_addr(page_addr),
        .busy(busy), .done(done), .pass(pass), .buf_rd(buf_rd),
        .buf_idx(buf_idx), .buf_data(buf_data), .nf_ce_n(nf_ce_n),
        .nf_wp_n(nf_wp_n), .nf_cle(nf_cle), .nf_ale(nf_ale),
        .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_io_out(nf_io_out),
        .nf_io_oe(nf_io_oe), .nf_io_in(nf_io_in), .nf_rdy(nf_rdy)
    );

    // compare one cycle, then drive the device's ready line and move on
    task automatic step(input logic ce_n, wp_n, cle, ale, we_n, re_n, oe,
                        input logic [7:0] io, input logic brd, input int idx,
                        input logic dn, ps, bsy, input string tag);
        bit bad;
        checks++;
        bad = (nf_ce_n !== ce_n) || (nf_wp_n !== wp_n) || (nf_cle !== cle) ||
              (nf_ale !== ale) || (nf_we_n !== we_n) || (nf_re_n !== re_n) ||
              (nf_io_oe !== oe) || (buf_rd !== brd) || (done !== dn) ||
              (busy !== bsy) || (oe && nf_io_out !== io) ||
              (brd && int'(buf_idx) != idx) || (dn && pass !== ps);
        if (bad) begin
            failures++;
            $display("FAIL %s cyc=%0d actual ce%b wp%b cle%b ale%b we%b re%b oe%b io=%h rd%b idx=%0d done%b pass%b busy%b expected ce%b wp%b cle%b ale%b we%b re%b oe%b io=%h rd%b idx=%0d done%b pass%b busy%b",
                     tag, cyc_n, nf_ce_n, nf_wp_n, nf_cle, nf_ale, nf_we_n, nf_re_n,
                     nf_io_oe, nf_io_out, buf_rd, buf_idx, done, pass, busy,
                     ce_n, wp_n, cle, ale, we_n, re_n, oe, io, brd, idx, dn, ps, bsy);
        end
        nf_rdy = (rdy_low_left > 0) ? 1'b0 : 1'b1;
        if (rdy_low_left > 0) rdy_low_left--;
        h2 = h1;
        h1 = nf_rdy;
        cyc_n++;
        @(negedge clk);
    endtask

    task automatic idle_cyc(input string tag);
        step(1, 0, 0, 0, 1, 1, 0, 8'h00, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic bus_write(input logic cle, ale, input logic [7:0] b,
                             input logic brd, input int idx, input string tag);
        for (int k = 0; k < PER; k++)
            step(0, 1, cle, ale, (k < LO) ? 1'b0 : 1'b1, 1, 1, b, brd, idx, 0, 0, 1, tag);
    endtask

    task automatic run_op(input logic [AW-1:0] a, input logic [7:0] st,
                          input int busy_len, input bit stray, input string name);
        int c;
        bit to;
        logic exp_pass;
        dev_status = st;
        page_addr = a;
        start = 1'b1;
        idle_cyc("R1 pre-start");
        start = 1'b0;
        for (int k = 0; k < PER; k++)
            step(0, 1, 0, 0, 1, 1, 0, 8'h00, 0, 0, 0, 0, 1, "R3 enable");
        bus_write(1, 0, 8'h80, 0, 0, "R5 load opcode");
        for (int i = 0; i < ADDR_CYC; i++) begin
            if (stray && i == 1) begin
                start = 1'b1;
                page_addr = ~a;
            end
            bus_write(0, 1, 8'(a >> (8 * i)), 0, 0, stray ? "R2 start ignored / R6 address" : "R6 address");
            start = 1'b0;
        end
        for (int i = 0; i < PAGE; i++)
            bus_write(0, 0, pat(i), 1, i, "R7 data");
        rdy_low_left = busy_len;
        bus_write(1, 0, 8'h10, 0, 0, "R8 program opcode");
        c = 0;
        to = 0;
        forever begin
            bit ex;
            bit lt;
            ex = (c >= GUARD) && h2;
            lt = (c == TMO - 1);
            step(0, 1, 0, 0, 1, 1, 0, 8'h00, 0, 0, 0, 0, 1, "R8 wait");
            if (ex) break;
            if (lt) begin
                to = 1;
                break;
            end
            c++;
        end
        if (to) begin
            exp_pass = 1'b0;
        end else begin
            bus_write(1, 0, 8'h70, 0, 0, "R9 status opcode");
            for (int k = 0; k < PER; k++)
                step(0, 1, 0, 0, 1, (k < LO) ? 1'b0 : 1'b1, 0, 8'h00, 0, 0, 0, 0, 1, "R9 status read");
            exp_pass = st[6] && !st[0];
        end
        step(1, 0, 0, 0, 1, 1, 0, 8'h00, 0, 0, 1, exp_pass, 1,
             to ? "R11 timeout finish" : "R10 R12 finish");
        idle_cyc("R12 back to idle");
        idle_cyc("R1 idle");
        rdy_low_left = 0;
        $display("op %s done", name);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog R12 actual=no-finish expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        idle_cyc("R1 in reset");
        idle_cyc("R1 in reset");
        rst_n = 1'b1;
        for (int k = 0; k < 4; k++) idle_cyc("R1 after reset");

        run_op(24'h0345A7, 8'hC0, 30, 1, "pass_stray");
        run_op(24'hFFEE01, 8'hC1, 12, 0, "fail_bit0");
        run_op(24'h5A5A5A, 8'h80, 5, 0, "fail_not_ready");
        run_op(24'h000102, 8'hE0, 0, 0, "guard_no_busy");
        run_op(24'h123456, 8'hC0, 1000000, 0, "timeout");
        run_op(24'hABCDEF, 8'h40, 3, 0, "recover");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule